// File: doc/BRIEF.md
# Bidirectional Data-Bus / General-Purpose I/O Port

This block controls one byte-wide group of bidirectional pins that has two roles. In expanded operation the pins carry the multiplexed external data bus. The bus-cycle type and the level of the E clock (sampled on the system clock) set the timing. On an external read, the pin levels are captured into a bus-read latch when E falls. On an external write, the internal data bus is driven onto the pins while E is high. An optional visibility setting also drives the internal data onto the pins during reads of internal addresses, so that external equipment can observe those reads.

In single-chip operation the same pins are general-purpose I/O. A data latch supplies the output levels. A per-bit direction register chooses which pins drive. A port read returns the latch bit for each output pin and the sensed pin level for each input pin.

In both roles, a wired-OR option turns each driver into a pull-down only. A halt input releases every pin.

Top module: `bidir_data_port`

## Requirements
- R1: After reset the data latch and the direction register are all zeros, so no pin is enabled and every output value is 0.
- R2: In single-chip mode (`mode_exp`=0), pin_oe equals the direction register (bit=1 means output) and pin_out equals the data latch. Writes through `reg_wr_dat` and `reg_wr_dir` take effect on the clock edge that samples the strobe.
- R3: In single-chip mode, each bit of `port_rd_data` is the data-latch bit when that pin is an output, and the sensed `pin_in` bit when it is an input.
- R4: In expanded mode, a write cycle (`cyc_kind`=2) drives `int_data` on all pins. The drive is enabled in every clock where `e_level` is 1, and in the one clock that follows the clock where E was last seen high. At all other times the drive is off.
- R5: In expanded mode, an internal read cycle (`cyc_kind`=3) drives the pins with the same timing as R4 when `opt_read_vis` is 1, and drives nothing when it is 0.
- R6: In expanded mode, an external read cycle (`cyc_kind`=1) never drives the pins. `bus_rd_data` takes the `pin_in` value present at the first clock edge where `e_level` is 0 after having been 1.
- R7: With `opt_wired_or`=1, in either mode, a pin is enabled only when its output value is 0. Pins whose output value is 1 are released to high impedance, and pin_out itself is unchanged.
- R8: While `halt` is 1, every pin_oe bit is 0 in every mode and cycle type.
- R9: `bus_rd_data` is unchanged by write, internal-read and idle cycles (`cyc_kind`=0), by single-chip operation, and by read cycles outside the falling edge of E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_exp | input | 1 | 1 = expanded (data bus), 0 = single-chip (GPIO) |
| halt | input | 1 | Halt state; releases all pins |
| opt_wired_or | input | 1 | Pull-down-only drive option |
| opt_read_vis | input | 1 | Drive internal read data on the pins |
| cyc_kind | input | 2 | 0 idle, 1 external read, 2 write, 3 internal read |
| e_level | input | 1 | Sampled level of the E clock |
| int_data | input | WIDTH | Internal data bus |
| reg_wdata | input | WIDTH | Data for register writes |
| reg_wr_dat | input | 1 | Write strobe for the data latch |
| reg_wr_dir | input | 1 | Write strobe for the direction register |
| pin_in | input | WIDTH | Sensed pin levels |
| pin_out | output | WIDTH | Per-pin output value |
| pin_oe | output | WIDTH | Per-pin output enable |
| bus_rd_data | output | WIDTH | Data captured on the last external read |
| port_rd_data | output | WIDTH | GPIO read value |

## Verification
Bus writes are tried with alternating-bit data over a full E pulse. This separates drive during E high, the one-clock hold after E falls, and the release afterwards. Internal reads are run with visibility on and then off, so that a wrong select between the cycle types shows up as drive or silence. External reads change `pin_in` before and after E falls, and are followed by write cycles with different data; this shows whether the capture happens on the right edge and whether it holds. GPIO tests use a split direction pattern (0x0F) with differing latch and pin values, wired-OR with mixed ones and zeros, and halt during a bus write.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_EXT_RD = 2'd1,
      CYC_WRITE  = 2'd2,
      CYC_INT_RD = 2'd3
   } cyc_kind_t;
endpackage

// File: rtl/bdp_e_phase.sv
module bdp_e_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic e_level,
   output logic e_fall,
   output logic drive_window
);
   logic e_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_q <= 1'b0;
      else        e_q <= e_level;
   end

   assign e_fall       = e_q & ~e_level;
   assign drive_window = e_level | e_q;
endmodule

// File: rtl/bdp_gpio_regs.sv
module bdp_gpio_regs #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] reg_wdata,
   input  logic             reg_wr_dat,
   input  logic             reg_wr_dir,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] dat_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] port_rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
         dir_q <= '0;
      end else begin
         if (reg_wr_dat) dat_q <= reg_wdata;
         if (reg_wr_dir) dir_q <= reg_wdata;
      end
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_rd
      assign port_rd_data[b] = dir_q[b] ? dat_q[b] : pin_in[b];
   end
endmodule

// File: rtl/bdp_read_latch.sv
module bdp_read_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] bus_rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bus_rd_data <= '0;
      else if (capture) bus_rd_data <= pin_in;
   end
endmodule

// File: rtl/bdp_pad_ctrl.sv
module bdp_pad_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic             mode_exp,
   input  logic             halt,
   input  logic             opt_wired_or,
   input  logic             bus_drive,
   input  logic [WIDTH-1:0] int_data,
   input  logic [WIDTH-1:0] dat_q,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   logic [WIDTH-1:0] val_sel;
   logic [WIDTH-1:0] en_sel;

   always_comb begin
      if (mode_exp) begin
         val_sel = int_data;
         en_sel  = {WIDTH{bus_drive}};
      end else begin
         val_sel = dat_q;
         en_sel  = dir_q;
      end
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_pad
      logic low_ok;
      assign low_ok     = ~opt_wired_or | ~val_sel[b];
      assign pin_out[b] = val_sel[b];
      assign pin_oe[b]  = ~halt & en_sel[b] & low_ok;
   end
endmodule

// File: rtl/bidir_data_port.sv
module bidir_data_port
   import bdp_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_exp,
   input  logic             halt,
   input  logic             opt_wired_or,
   input  logic             opt_read_vis,
   input  logic [1:0]       cyc_kind,
   input  logic             e_level,
   input  logic [WIDTH-1:0] int_data,
   input  logic [WIDTH-1:0] reg_wdata,
   input  logic             reg_wr_dat,
   input  logic             reg_wr_dir,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] bus_rd_data,
   output logic [WIDTH-1:0] port_rd_data
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("bidir_data_port: WIDTH out of range");
   end

   cyc_kind_t        kind;
   logic             e_fall;
   logic             drive_window;
   logic             cyc_drives;
   logic             bus_drive;
   logic             capture;
   logic [WIDTH-1:0] dat_q;
   logic [WIDTH-1:0] dir_q;

   assign kind = cyc_kind_t'(cyc_kind);

   always_comb begin
      unique case (kind)
         CYC_WRITE:  cyc_drives = 1'b1;
         CYC_INT_RD: cyc_drives = opt_read_vis;
         default:    cyc_drives = 1'b0;
      endcase
   end

   assign bus_drive = cyc_drives & drive_window;
   assign capture   = mode_exp & (kind == CYC_EXT_RD) & e_fall;

   bdp_e_phase i_e_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .e_level      (e_level),
      .e_fall       (e_fall),
      .drive_window (drive_window)
   );

   bdp_gpio_regs #(.WIDTH(WIDTH)) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_wdata    (reg_wdata),
      .reg_wr_dat   (reg_wr_dat),
      .reg_wr_dir   (reg_wr_dir),
      .pin_in       (pin_in),
      .dat_q        (dat_q),
      .dir_q        (dir_q),
      .port_rd_data (port_rd_data)
   );

   bdp_read_latch #(.WIDTH(WIDTH)) i_rd_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .capture      (capture),
      .pin_in       (pin_in),
      .bus_rd_data  (bus_rd_data)
   );

   bdp_pad_ctrl #(.WIDTH(WIDTH)) i_pads (
      .mode_exp     (mode_exp),
      .halt         (halt),
      .opt_wired_or (opt_wired_or),
      .bus_drive    (bus_drive),
      .int_data     (int_data),
      .dat_q        (dat_q),
      .dir_q        (dir_q),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe)
   );
endmodule

// File: rtl/bidir_data_port_chk.sv
module bidir_data_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_exp,
   input logic             halt,
   input logic             opt_wired_or,
   input logic             opt_read_vis,
   input logic [1:0]       cyc_kind,
   input logic             e_level,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] bus_rd_data
);
   // R8: halt releases every pin
   a_r8_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> (pin_oe == '0));

   // R7: wired-OR never enables a pin whose value is 1
   a_r7_pull_down_only: assert property (@(posedge clk) disable iff (!rst_n)
      opt_wired_or |-> ((pin_oe & pin_out) == '0));

   // R6: external reads never drive
   a_r6_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_exp && cyc_kind == 2'd1) |-> (pin_oe == '0));

   // R6: capture at the falling edge of E
   a_r6_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_exp && cyc_kind == 2'd1 && !e_level && $past(e_level))
      |=> (bus_rd_data == $past(pin_in)));

   // R9: latch holds outside the capture point
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_exp && cyc_kind == 2'd1 && !e_level && $past(e_level))
      |=> $stable(bus_rd_data));

   // R4: no bus drive once E has been low for two samples
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_exp && !e_level && !$past(e_level)) |-> (pin_oe == '0));

   // R5: internal reads stay silent without visibility
   a_r5_no_vis_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_exp && cyc_kind == 2'd3 && !opt_read_vis) |-> (pin_oe == '0));
endmodule

bind bidir_data_port bidir_data_port_chk #(.WIDTH(WIDTH)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_exp     (mode_exp),
   .halt         (halt),
   .opt_wired_or (opt_wired_or),
   .opt_read_vis (opt_read_vis),
   .cyc_kind     (cyc_kind),
   .e_level      (e_level),
   .pin_in       (pin_in),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe),
   .bus_rd_data  (bus_rd_data)
);

// File: tb/test_bidir_data_port.sv
`timescale 1ns/1ps
module test_bidir_data_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_exp = 1'b0;
   logic         halt = 1'b0;
   logic         opt_wired_or = 1'b0;
   logic         opt_read_vis = 1'b0;
   logic [1:0]   cyc_kind = 2'd0;
   logic         e_level = 1'b0;
   logic [W-1:0] int_data = '0;
   logic [W-1:0] reg_wdata = '0;
   logic         reg_wr_dat = 1'b0;
   logic         reg_wr_dir = 1'b0;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_out, pin_oe, bus_rd_data, port_rd_data;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bidir_data_port #(.WIDTH(W)) i_bidir_data_port (
      .clk(clk), .rst_n(rst_n), .mode_exp(mode_exp), .halt(halt),
      .opt_wired_or(opt_wired_or), .opt_read_vis(opt_read_vis),
      .cyc_kind(cyc_kind), .e_level(e_level), .int_data(int_data),
      .reg_wdata(reg_wdata), .reg_wr_dat(reg_wr_dat), .reg_wr_dir(reg_wr_dir),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .bus_rd_data(bus_rd_data), .port_rd_data(port_rd_data)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // advance to the next falling clock edge, then settle
   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic idle_low();
      e_level = 1'b0; cyc_kind = 2'd0;
      step(); step();
   endtask

   task automatic wr_reg(input logic dat, input logic dir, input logic [W-1:0] v);
      reg_wdata = v; reg_wr_dat = dat; reg_wr_dir = dir;
      step();
      reg_wr_dat = 1'b0; reg_wr_dir = 1'b0;
   endtask

   task automatic t_reset();
      step();
      chk("R1 oe after reset", pin_oe, 8'h00);
      chk("R1 out after reset", pin_out, 8'h00);
   endtask

   task automatic t_gpio();
      mode_exp = 1'b0;
      wr_reg(1'b1, 1'b0, 8'hA6);
      wr_reg(1'b0, 1'b1, 8'h0F);
      chk("R2 oe follows direction", pin_oe, 8'h0F);
      chk("R2 out follows latch", pin_out, 8'hA6);
      pin_in = 8'h59; #1;
      chk("R3 mixed read", port_rd_data, 8'h56);
      wr_reg(1'b0, 1'b1, 8'hF0);
      chk("R2 direction rewrite", pin_oe, 8'hF0);
      chk("R3 read after direction change", port_rd_data, 8'hA9);
   endtask

   task automatic t_bus_write();
      mode_exp = 1'b1; idle_low();
      cyc_kind = 2'd2; int_data = 8'hA5; #1;
      chk("R4 no drive before E", pin_oe, 8'h00);
      e_level = 1'b1; #1;
      chk("R4 drive at E high", pin_oe, 8'hFF);
      chk("R4 write value", pin_out, 8'hA5);
      step();
      chk("R4 drive E still high", pin_oe, 8'hFF);
      e_level = 1'b0; #1;
      chk("R4 hold after E fall", pin_oe, 8'hFF);
      step();
      chk("R4 release", pin_oe, 8'h00);
      idle_low();
   endtask

   task automatic t_vis();
      mode_exp = 1'b1; idle_low();
      cyc_kind = 2'd3; int_data = 8'h3C; opt_read_vis = 1'b1;
      e_level = 1'b1; #1;
      chk("R5 visible internal read", pin_oe, 8'hFF);
      chk("R5 visible value", pin_out, 8'h3C);
      e_level = 1'b0; step(); step();
      opt_read_vis = 1'b0; e_level = 1'b1; #1;
      chk("R5 hidden internal read", pin_oe, 8'h00);
      e_level = 1'b0; idle_low();
   endtask

   task automatic t_ext_read();
      mode_exp = 1'b1; idle_low();
      cyc_kind = 2'd1; e_level = 1'b1; pin_in = 8'h11; #1;
      chk("R6 read does not drive", pin_oe, 8'h00);
      step();
      chk("R9 no capture while E high", bus_rd_data, 8'h00);
      e_level = 1'b0; pin_in = 8'hC3;
      step();
      chk("R6 captured at E fall", bus_rd_data, 8'hC3);
      pin_in = 8'h77; step();
      chk("R9 hold after fall", bus_rd_data, 8'hC3);
      cyc_kind = 2'd2; int_data = 8'h5A; e_level = 1'b1; step();
      e_level = 1'b0; step(); step();
      chk("R9 hold over write", bus_rd_data, 8'hC3);
      cyc_kind = 2'd3; opt_read_vis = 1'b1; e_level = 1'b1; step();
      e_level = 1'b0; step(); step();
      opt_read_vis = 1'b0;
      chk("R9 hold over internal read", bus_rd_data, 8'hC3);
      mode_exp = 1'b0; cyc_kind = 2'd1; e_level = 1'b1; step();
      e_level = 1'b0; step(); step();
      chk("R9 no capture in single-chip", bus_rd_data, 8'hC3);
      idle_low();
   endtask

   task automatic t_wired_or();
      mode_exp = 1'b1; opt_wired_or = 1'b1; idle_low();
      cyc_kind = 2'd2; int_data = 8'hA5; e_level = 1'b1; #1;
      chk("R7 bus pull-down only", pin_oe, 8'h5A);
      chk("R7 value unchanged", pin_out, 8'hA5);
      e_level = 1'b0; idle_low();
      mode_exp = 1'b0;
      wr_reg(1'b1, 1'b0, 8'h33);
      wr_reg(1'b0, 1'b1, 8'h0F);
      chk("R7 gpio pull-down only", pin_oe, 8'h0C);
      opt_wired_or = 1'b0;
   endtask

   task automatic t_halt();
      mode_exp = 1'b0; wr_reg(1'b0, 1'b1, 8'hFF);
      halt = 1'b1; #1;
      chk("R8 halt gpio", pin_oe, 8'h00);
      mode_exp = 1'b1; cyc_kind = 2'd2; int_data = 8'hFF; e_level = 1'b1; #1;
      chk("R8 halt bus write", pin_oe, 8'h00);
      halt = 1'b0; #1;
      chk("R4 drive after halt clears", pin_oe, 8'hFF);
      e_level = 1'b0; idle_low();
   endtask

   initial begin
      #200_000_0;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      #2 rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
      t_reset();
      t_gpio();
      t_bus_write();
      t_vis();
      t_ext_read();
      t_wired_or();
      t_halt();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule